// File: doc/BRIEF.md
# Stereo Serial Audio Transmitter

This block turns parallel stereo samples into two synchronous serial audio streams. From the system clock it derives a bit clock and one frame-sync/word-select output, and both data lines (primary and secondary) use them. Each line carries its own left/right pair. The frame format is picked per frame from three framings: left-justified, I2S and DSP. The word length can be set anywhere from 3 to 32 bits per channel. Each channel occupies a fixed number of bit-clock slots (32 by default, so the bit clock runs at 64 times the sample rate). A different slot count gives a burst ratio.

Samples arrive through a ready/valid port that takes one stereo pair for each line in a single transfer. That transfer fills a one-deep holding stage, which is moved into the shifting stage at each frame boundary. If no new pair is waiting at a boundary, the previous pair is sent again and an underrun flag is held for that frame. Data and frame sync change only on the falling edge of the bit clock, so a receiver samples them on the rising edge.

Top module: `audtx_top`

## Requirements
- R1: While reset is held and immediately after it is released, bclk, fsync, priData, secData and underrun are 0 and inReady is 1.
- R2: Each channel word is sent most-significant bit first and ends with bit 0. Every slot of a channel period after the last word bit is driven 0.
- R3: With mode 0 or mode 3 (left-justified), fsync is 1 during the 32 slots of the left channel and 0 during the 32 slots of the right channel. The MSB is in the first slot of each channel.
- R4: With mode 1 (I2S), fsync is 0 for the left channel and 1 for the right channel. Each MSB appears one slot after the fsync change. With a 32-bit word, the right channel's bit 0 falls in slot 0 of the next frame.
- R5: With mode 2 (DSP), fsync is a pulse one slot wide in the last slot of each channel period, which gives two pulses per frame. The MSB of the next word follows in the slot after each pulse.
- R6: The effective word length is wordLen clamped to the range 3..32. A value below 3 sends 3 bits and a value above 32 sends 32 bits.
- R7: secData carries its own secLeft/secRight pair with the same timing, framing and word length as priData.
- R8: When no pair is waiting at a frame boundary, the previous pair is repeated and underrun is 1 for that whole frame. A frame that loads a new pair has underrun 0. underrun changes only at a frame boundary.
- R9: A transfer happens when inValid and inReady are both 1. inReady then stays 0 until the next frame boundary. The pair accepted first is sent in the next frame, and a pair accepted after that boundary is sent in the frame after it.
- R10: Changes to mode and wordLen take effect only at a frame boundary. A change made in mid-frame leaves the rest of that frame unchanged.
- R11: The bit clock period is 2*HALF_DIV system clocks (4 by default). fsync, priData, secData and underrun change only in the cycle in which bclk falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Framing: 0 left-justified, 1 I2S, 2 DSP, 3 left-justified |
| wordLen | input | 6 | Requested bits per channel word (clamped to 3..32) |
| inValid | input | 1 | A stereo pair for both lines is offered |
| inReady | output | 1 | Holding stage is empty and can accept a pair |
| priLeft | input | 32 | Primary line left sample, right-aligned |
| priRight | input | 32 | Primary line right sample, right-aligned |
| secLeft | input | 32 | Secondary line left sample, right-aligned |
| secRight | input | 32 | Secondary line right sample, right-aligned |
| bclk | output | 1 | Bit clock |
| fsync | output | 1 | Frame sync / word select |
| priData | output | 1 | Primary serial data |
| secData | output | 1 | Secondary serial data |
| underrun | output | 1 | The current frame repeats the previous pair |

## Verification
The bench aims at the I2S one-slot delay at full 32-bit length. There the right LSB spills into the next frame, and a design missing the delay would put that bit in the wrong slot or lose it. It also covers the DSP pulse in the last slot of each channel, the clamping of word lengths 0 and 50, and word length 3. A design that counts from the wrong end would shift words or leave stale bits after the LSB. Three further cases are a mode change in mid-frame, a second pair offered while the holding stage is full, and a frame with no new data. A wrong design would switch framing too early, overwrite the pending pair, or stop sending instead of repeating with the flag set.

// File: rtl/audtx_pkg.sv
package audtx_pkg;

  typedef enum logic [1:0] {
    FMT_LJ  = 2'd0,
    FMT_I2S = 2'd1,
    FMT_DSP = 2'd2
  } fmt_e;

  // strobes from control to each data lane
  typedef struct packed {
    logic fallEv;     // bit clock falls this cycle, a new slot starts
    logic accept;     // a parallel pair enters the holding stage
    logic frameLoad;  // holding stage moves into the shifting stage
  } strobe_t;

  function automatic fmt_e decodeMode(input logic [1:0] m);
    case (m)
      2'd1:    decodeMode = FMT_I2S;
      2'd2:    decodeMode = FMT_DSP;
      default: decodeMode = FMT_LJ;
    endcase
  endfunction

endpackage

// File: rtl/audtx_ctrl.sv
module audtx_ctrl
  import audtx_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int SLOTS    = 32,
  parameter int MAX_WL   = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [1:0]                   modeIn,
  input  logic [$clog2(MAX_WL+1)-1:0]  wordLenIn,
  input  logic                         inValid,
  output logic                         inReady,
  output strobe_t                      strb,
  output logic                         newCh,
  output logic [$clog2(SLOTS)-1:0]     newPos,
  output fmt_e                         nextFmt,
  output logic [$clog2(MAX_WL+1)-1:0]  nextWl,
  output logic                         bclk,
  output logic                         fsync,
  output logic                         underrun
);

  localparam int FRAME_SLOTS = 2 * SLOTS;
  localparam int SLOT_W      = $clog2(FRAME_SLOTS);
  localparam int POS_W       = $clog2(SLOTS);
  localparam int HALF_W      = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int WL_W        = $clog2(MAX_WL + 1);
  localparam int WL_CAP      = (MAX_WL < SLOTS) ? MAX_WL : SLOTS;
  localparam int WL_MIN      = 3;

  logic [HALF_W-1:0] halfCnt;
  logic              bclkR;
  logic [SLOT_W-1:0] slot;
  logic [SLOT_W-1:0] nextSlot;
  fmt_e              fmtAct;
  logic [WL_W-1:0]   wlAct;
  logic [WL_W-1:0]   wlReq;
  logic              pendFull;
  logic              underrunR;
  logic              fsyncR;
  logic              tick;
  logic              boundary;
  logic              fsNext;

  always_comb begin
    if (wordLenIn < WL_W'(WL_MIN))      wlReq = WL_W'(WL_MIN);
    else if (wordLenIn > WL_W'(WL_CAP)) wlReq = WL_W'(WL_CAP);
    else                                wlReq = wordLenIn;
  end

  always_comb begin
    tick     = (halfCnt == HALF_W'(HALF_DIV - 1));
    nextSlot = (slot == SLOT_W'(FRAME_SLOTS - 1)) ? '0 : slot + 1'b1;
    boundary = tick && bclkR && (nextSlot == '0);
    newCh    = (nextSlot >= SLOT_W'(SLOTS));
    newPos   = newCh ? POS_W'(nextSlot - SLOT_W'(SLOTS)) : POS_W'(nextSlot);
    nextFmt  = boundary ? decodeMode(modeIn) : fmtAct;
    nextWl   = boundary ? wlReq : wlAct;
    strb.fallEv    = tick && bclkR;
    strb.accept    = inValid && !pendFull;
    strb.frameLoad = boundary && pendFull;
  end

  always_comb begin
    case (nextFmt)
      FMT_I2S: fsNext = newCh;
      FMT_DSP: fsNext = (newPos == POS_W'(SLOTS - 1));
      default: fsNext = !newCh;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      halfCnt   <= '0;
      bclkR     <= 1'b0;
      slot      <= SLOT_W'(FRAME_SLOTS - 1);
      fsyncR    <= 1'b0;
      fmtAct    <= FMT_LJ;
      wlAct     <= WL_W'(WL_CAP);
      underrunR <= 1'b0;
      pendFull  <= 1'b0;
    end else begin
      if (tick) begin
        halfCnt <= '0;
        bclkR   <= !bclkR;
      end else begin
        halfCnt <= halfCnt + 1'b1;
      end
      if (strb.fallEv) begin
        slot   <= nextSlot;
        fsyncR <= fsNext;
      end
      if (boundary) begin
        fmtAct    <= nextFmt;
        wlAct     <= nextWl;
        underrunR <= !pendFull;
      end
      if (strb.frameLoad)   pendFull <= 1'b0;
      else if (strb.accept) pendFull <= 1'b1;
    end
  end

  assign bclk     = bclkR;
  assign fsync    = fsyncR;
  assign underrun = underrunR;
  assign inReady  = !pendFull;

endmodule

// File: rtl/audtx_lane.sv
module audtx_lane
  import audtx_pkg::*;
#(
  parameter int SLOTS  = 32,
  parameter int MAX_WL = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  strobe_t                      strb,
  input  logic                         newCh,
  input  logic [$clog2(SLOTS)-1:0]     newPos,
  input  fmt_e                         fmt,
  input  logic [$clog2(MAX_WL+1)-1:0]  wl,
  input  logic [MAX_WL-1:0]            leftIn,
  input  logic [MAX_WL-1:0]            rightIn,
  output logic                         dataOut
);

  localparam int IDX_W = (MAX_WL > 1) ? $clog2(MAX_WL) : 1;

  logic [MAX_WL-1:0] pendL, pendR, actL, actR, word;
  logic [IDX_W-1:0]  idx;
  logic              bitNow;
  logic              bitDly;
  logic              dataR;

  always_comb begin
    if (strb.frameLoad) word = newCh ? pendR : pendL;
    else                word = newCh ? actR : actL;
    if (int'(newPos) < int'(wl)) begin
      idx    = IDX_W'(int'(wl) - 1 - int'(newPos));
      bitNow = word[idx];
    end else begin
      idx    = '0;
      bitNow = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pendL  <= '0;
      pendR  <= '0;
      actL   <= '0;
      actR   <= '0;
      bitDly <= 1'b0;
      dataR  <= 1'b0;
    end else begin
      if (strb.accept) begin
        pendL <= leftIn;
        pendR <= rightIn;
      end
      if (strb.frameLoad) begin
        actL <= pendL;
        actR <= pendR;
      end
      if (strb.fallEv) begin
        bitDly <= bitNow;
        dataR  <= (fmt == FMT_I2S) ? bitDly : bitNow;
      end
    end
  end

  assign dataOut = dataR;

endmodule

// File: rtl/audtx_top.sv
module audtx_top
  import audtx_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int SLOTS    = 32,
  parameter int MAX_WL   = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [1:0]                   mode,
  input  logic [$clog2(MAX_WL+1)-1:0]  wordLen,
  input  logic                         inValid,
  output logic                         inReady,
  input  logic [MAX_WL-1:0]            priLeft,
  input  logic [MAX_WL-1:0]            priRight,
  input  logic [MAX_WL-1:0]            secLeft,
  input  logic [MAX_WL-1:0]            secRight,
  output logic                         bclk,
  output logic                         fsync,
  output logic                         priData,
  output logic                         secData,
  output logic                         underrun
);

  localparam int NUM_LINES = 2;
  localparam int POS_W     = $clog2(SLOTS);
  localparam int WL_W      = $clog2(MAX_WL + 1);

  strobe_t          strb;
  logic             newCh;
  logic [POS_W-1:0] newPos;
  fmt_e             nextFmt;
  logic [WL_W-1:0]  nextWl;

  logic [MAX_WL-1:0] leftArr  [NUM_LINES];
  logic [MAX_WL-1:0] rightArr [NUM_LINES];
  logic              lineOut  [NUM_LINES];

  assign leftArr[0]  = priLeft;
  assign rightArr[0] = priRight;
  assign leftArr[1]  = secLeft;
  assign rightArr[1] = secRight;

  audtx_ctrl #(
    .HALF_DIV(HALF_DIV), .SLOTS(SLOTS), .MAX_WL(MAX_WL)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .modeIn(mode), .wordLenIn(wordLen),
    .inValid(inValid), .inReady(inReady), .strb(strb),
    .newCh(newCh), .newPos(newPos), .nextFmt(nextFmt), .nextWl(nextWl),
    .bclk(bclk), .fsync(fsync), .underrun(underrun)
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    audtx_lane #(.SLOTS(SLOTS), .MAX_WL(MAX_WL)) u_lane (
      .clk(clk), .rst_n(rst_n), .strb(strb), .newCh(newCh),
      .newPos(newPos), .fmt(nextFmt), .wl(nextWl),
      .leftIn(leftArr[g]), .rightIn(rightArr[g]), .dataOut(lineOut[g])
    );
  end

  assign priData = lineOut[0];
  assign secData = lineOut[1];

endmodule

// File: rtl/audtx_checker.sv
module audtx_checker (
  input logic clk,
  input logic rst_n,
  input logic bclk,
  input logic fsync,
  input logic priData,
  input logic secData,
  input logic underrun,
  input logic inValid,
  input logic inReady
);

  AST_DATA_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(priData) || !$stable(secData)) |-> $fell(bclk)); // R11

  AST_FS_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fsync) |-> $fell(bclk)); // R11

  AST_UNDERRUN_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(underrun) |-> $fell(bclk)); // R8

  AST_HOLD_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && inReady) |=> !inReady); // R9

  AST_READY_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(inReady) |-> $fell(bclk)); // R9

endmodule

bind audtx_top audtx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync),
  .priData(priData), .secData(secData), .underrun(underrun),
  .inValid(inValid), .inReady(inReady)
);

// File: tb/sim_audtx_top.sv
module sim_audtx_top;

  localparam int FR   = 64;
  localparam int HIST = 4096;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  mode;
  logic [5:0]  wordLen;
  logic        inValid;
  logic        inReady;
  logic [31:0] priLeft, priRight, secLeft, secRight;
  logic        bclk, fsync, priData, secData, underrun;

  always #4 clk = ~clk;

  audtx_top u0 (
    .clk(clk), .rst_n(rst_n), .mode(mode), .wordLen(wordLen),
    .inValid(inValid), .inReady(inReady),
    .priLeft(priLeft), .priRight(priRight),
    .secLeft(secLeft), .secRight(secRight),
    .bclk(bclk), .fsync(fsync), .priData(priData), .secData(secData),
    .underrun(underrun)
  );

  int nChecks = 0;
  int nFails  = 0;
  int cyc     = 0;
  int riseCnt = 0;
  int curSlot = -1;
  int edgeViol = 0;
  logic histFs [HIST];
  logic histP  [HIST];
  logic histS  [HIST];
  logic lastB = 1'b0, lastF = 1'b0, lastP = 1'b0, lastS = 1'b0, lastU = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // receiver: sample on rising bit clock
  always @(posedge bclk) begin
    if (riseCnt >= 1) begin
      histFs[(riseCnt - 1) % HIST] = fsync;
      histP[(riseCnt - 1) % HIST]  = priData;
      histS[(riseCnt - 1) % HIST]  = secData;
      curSlot = riseCnt - 1;
    end
    riseCnt++;
  end

  // outputs may only move together with a bclk fall (R11)
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if ((fsync !== lastF || priData !== lastP || secData !== lastS ||
           underrun !== lastU) && !(lastB === 1'b1 && bclk === 1'b0))
        edgeViol++;
    end
    lastB = bclk; lastF = fsync; lastP = priData; lastS = secData; lastU = underrun;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic ljAt(input logic [31:0] l, input logic [31:0] r,
                                input int wl, input int k);
    int pos = k % 32;
    logic [31:0] w = (k >= 32) ? r : l;
    return (pos < wl) ? w[wl - 1 - pos] : 1'b0;
  endfunction

  task automatic waitSlot(input int t);
    while (curSlot < t) @(negedge clk);
  endtask

  task automatic waitFrameStart(output int f);
    int s0 = curSlot;
    do @(negedge clk); while (!(curSlot != s0 && curSlot >= 0 && curSlot % FR == 0));
    f = curSlot / FR;
  endtask

  task automatic pushPair(input logic [31:0] pl, pr, sl, sr);
    forever begin
      @(negedge clk);
      if (inReady) break;
    end
    inValid = 1'b1; priLeft = pl; priRight = pr; secLeft = sl; secRight = sr;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic checkFrame(input int f, input int m, input int wl,
                            input logic [31:0] pl, pr, sl, sr, input string req);
    int fsBad = 0, pBad = 0, sBad = 0;
    logic fa = 0, fe = 0, pa = 0, pe = 0, sa = 0, se = 0;
    waitSlot((f + 1) * FR + 1);
    for (int o = 0; o < FR; o++) begin
      logic e;
      int pos = o % 32;
      case (m)
        1:       e = (o >= 32);
        2:       e = (pos == 31);
        default: e = (o < 32);
      endcase
      if (histFs[(f * FR + o) % HIST] !== e) begin
        if (fsBad == 0) begin fa = histFs[(f * FR + o) % HIST]; fe = e; end
        fsBad++;
      end
    end
    for (int o = (m == 1) ? 1 : 0; o <= ((m == 1) ? FR : FR - 1); o++) begin
      int k = (m == 1) ? o - 1 : o;
      logic ep = ljAt(pl, pr, wl, k);
      logic es = ljAt(sl, sr, wl, k);
      if (histP[(f * FR + o) % HIST] !== ep) begin
        if (pBad == 0) begin pa = histP[(f * FR + o) % HIST]; pe = ep; end
        pBad++;
      end
      if (histS[(f * FR + o) % HIST] !== es) begin
        if (sBad == 0) begin sa = histS[(f * FR + o) % HIST]; se = es; end
        sBad++;
      end
    end
    chk(fsBad == 0, req, $sformatf("fsync pattern frame %0d (bad slots %0d)", f, fsBad), fa, fe);
    chk(pBad == 0, req, $sformatf("priData frame %0d (bad slots %0d)", f, pBad), pa, pe);
    chk(sBad == 0, "R7", $sformatf("secData frame %0d (bad slots %0d)", f, sBad), sa, se);
  endtask

  task automatic runFmt(input int m, input int wlIn, input int wlExp,
                        input logic [31:0] pl, pr, sl, sr, input string req,
                        output int f);
    waitFrameStart(f);
    mode = 2'(m);
    wordLen = 6'(wlIn);
    pushPair(pl, pr, sl, sr);
    checkFrame(f + 1, m, wlExp, pl, pr, sl, sr, req);
  endtask

  task automatic testReset();
    chk(bclk === 1'b0, "R1", "bclk in reset", bclk, 0);
    chk(fsync === 1'b0 && priData === 1'b0 && secData === 1'b0, "R1",
        "fsync/data in reset", {fsync, priData, secData}, 0);
    chk(underrun === 1'b0 && inReady === 1'b1, "R1", "flags in reset",
        {underrun, inReady}, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(bclk === 1'b0 && fsync === 1'b0 && priData === 1'b0 && underrun === 1'b0,
        "R1", "outputs after release", {bclk, fsync, priData, underrun}, 0);
  endtask

  task automatic testClock();
    int c0;
    int s0 = curSlot;
    while (curSlot == s0) @(negedge clk);
    c0 = cyc; s0 = curSlot;
    while (curSlot == s0) @(negedge clk);
    chk(cyc - c0 == 4, "R11", "bit clock period in clocks", cyc - c0, 4);
  endtask

  task automatic testUnderrun();
    int f;
    logic [31:0] a = 32'h0000_B00F, b = 32'h0000_4C21, c = 32'h0000_91E7, d = 32'h0000_3A5C;
    waitFrameStart(f);
    mode = 2'd0; wordLen = 6'd16;
    pushPair(a, b, c, d);
    waitSlot((f + 1) * FR + 5);
    chk(underrun === 1'b0, "R8", "underrun in loaded frame", underrun, 0);
    checkFrame(f + 1, 0, 16, a, b, c, d, "R8");
    waitSlot((f + 2) * FR + 5);
    chk(underrun === 1'b1, "R8", "underrun in repeated frame", underrun, 1);
    checkFrame(f + 2, 0, 16, a, b, c, d, "R8");
  endtask

  task automatic testReady();
    int f;
    int early = 0;
    logic [31:0] a = 32'hDEAD_BEEF, b = 32'h0123_4567;
    logic [31:0] c = 32'hCAFE_F00D, d = 32'h89AB_CDEF;
    waitFrameStart(f);
    mode = 2'd0; wordLen = 6'd32;
    pushPair(a, b, c, d);
    chk(inReady === 1'b0, "R9", "inReady after accept", inReady, 0);
    inValid = 1'b1; priLeft = b; priRight = a; secLeft = d; secRight = c;
    forever begin
      @(negedge clk);
      if (inReady) begin
        if (curSlot < (f + 1) * FR - 1) early++;
        @(negedge clk);
        inValid = 1'b0;
        break;
      end
    end
    chk(early == 0, "R9", "inReady rose before frame boundary", early, 0);
    checkFrame(f + 1, 0, 32, a, b, c, d, "R9");
    checkFrame(f + 2, 0, 32, b, a, d, c, "R9");
  endtask

  task automatic testMidChange();
    int f;
    logic [31:0] a = 32'h0000_F0A5, b = 32'h0000_0FF1, c = 32'h0000_8001, d = 32'h0000_7E3C;
    waitFrameStart(f);
    mode = 2'd0; wordLen = 6'd16;
    pushPair(a, b, c, d);
    waitSlot((f + 1) * FR + 20);
    mode = 2'd2; wordLen = 6'd8;
    checkFrame(f + 1, 0, 16, a, b, c, d, "R10");
    checkFrame(f + 2, 2, 8, a, b, c, d, "R10");
  endtask

  initial begin
    int f;
    rst_n = 1'b0; inValid = 1'b0; mode = 2'd0; wordLen = 6'd32;
    priLeft = '0; priRight = '0; secLeft = '0; secRight = '0;
    repeat (3) @(negedge clk);
    testReset();
    testClock();
    runFmt(0, 24, 24, 32'h00A5_C31E, 32'h007F_0281, 32'h0012_3456, 32'h00FE_DCBA, "R2 R3", f);
    runFmt(3, 20, 20, 32'h000C_0FFE, 32'h0008_1234, 32'h000F_FFFF, 32'h0000_0001, "R3", f);
    runFmt(1, 16, 16, 32'h0000_ACE1, 32'h0000_5A3C, 32'h0000_1357, 32'h0000_9BDF, "R4", f);
    runFmt(1, 32, 32, 32'h8000_0001, 32'hC000_0003, 32'h7FFF_FFFE, 32'h1234_5679, "R4", f);
    runFmt(2, 20, 20, 32'h000A_BCDE, 32'h0005_4321, 32'h000F_0F0F, 32'h0000_F0F1, "R5", f);
    runFmt(0, 3, 3, 32'h0000_0005, 32'h0000_0003, 32'h0000_0006, 32'h0000_0001, "R6 R2", f);
    runFmt(1, 0, 3, 32'h0000_0006, 32'h0000_0001, 32'h0000_0003, 32'h0000_0007, "R6", f);
    runFmt(2, 50, 32, 32'hF00D_1234, 32'h0BAD_C0DE, 32'h5555_AAAA, 32'hA5A5_0F0F, "R6", f);
    testUnderrun();
    testReady();
    testMidChange();
    chk(edgeViol == 0, "R11", "output changes away from bclk fall", edgeViol, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    #(200000 * 8);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule